// File: doc/BRIEF.md
# Scoreboarded Multi-Warp Issue Scheduler

This block sits between instruction fetch and the execution pipes of a multithreaded SIMD core. Each warp owns one buffer slot that holds its next instruction. The fetch side writes at most one instruction per cycle into the slot of any warp. The scheduler sends out at most one instruction per cycle, and that instruction comes from any warp whose operands are all available. A per-warp register scoreboard tracks the results that are still in flight. When an instruction that writes a register issues, its destination is marked pending. A writeback port clears that mark later.

A warp whose operands are not ready waits in its slot and does not hold back the other warps. Among the ready warps, the choice follows either a rotating round-robin order or the order in which the instructions were fetched (oldest first). A parameter selects which of the two. An issued instruction occupies the shared pipe for a fixed number of clocks, because the pipe broadcasts it over all lanes of the warp. The next issue therefore waits that many clocks. The instruction cache, the execution units and the lane datapaths lie outside this block.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no instruction issues and no warp is busy, and every scoreboard entry is ready, so the first fetched instruction may issue whatever registers it names.
- R2: A fetch writes the instruction into the slot of the addressed warp only when that slot is empty, and `warp_busy` for that warp is 1 in the next cycle. A fetch to a busy slot is ignored: the instruction already held is the one that issues.
- R3: A buffered instruction is eligible only when source A and source B are not pending in its own warp's scoreboard and, if it writes (`fetch_wr`=1), its destination is not pending either.
- R4: At most one instruction issues per cycle. `issue_warp`, `issue_op`, `issue_dst` and `issue_wr` show the fields of the instruction fetched into that warp's slot, and the slot is empty in the cycle after the issue.
- R5: The issue of an instruction with the write flag set marks its destination pending in its own warp from the next cycle on. An instruction with the write flag clear marks nothing.
- R6: A writeback (`wb_valid[p]` with warp field bits [p*WID_W +: WID_W] and register field bits [p*REG_W +: REG_W]) clears only that warp's register, effective in the next cycle. All writeback ports act in the same cycle.
- R7: When a writeback and an issue that sets the same warp and register fall in the same cycle, the register stays pending.
- R8: Two issues are at least ISSUE_GAP (default 4) cycles apart. When ready work is waiting, the next issue comes exactly ISSUE_GAP cycles after the previous one.
- R9: A warp stalled on the scoreboard never prevents another eligible warp from issuing.
- R10: In round-robin mode the search starts at the warp after the one that last issued and wraps around. After reset it starts at warp 0.
- R11: In oldest-first mode the eligible warp whose instruction was fetched earliest issues first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_valid | input | 1 | Fetch request this cycle |
| fetch_warp | input | WID_W | Warp whose slot is written |
| fetch_op | input | OP_W | Opaque instruction payload |
| fetch_dst | input | REG_W | Destination register |
| fetch_src_a | input | REG_W | First source register |
| fetch_src_b | input | REG_W | Second source register |
| fetch_wr | input | 1 | Instruction writes its destination |
| wb_valid | input | NUM_WB | Writeback strobe per port |
| wb_warp | input | NUM_WB*WID_W | Warp of each writeback port |
| wb_reg | input | NUM_WB*REG_W | Register of each writeback port |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | WID_W | Warp of the issued instruction |
| issue_op | output | OP_W | Payload of the issued instruction |
| issue_dst | output | REG_W | Destination of the issued instruction |
| issue_wr | output | 1 | Write flag of the issued instruction |
| warp_busy | output | NUM_WARPS | Slot of each warp holds an instruction |

## Verification
Two things can fall in the same cycle here: the issue that marks a register pending and a writeback that clears the same register. The bench provokes this by fetching a writing instruction into an idle scheduler, which issues it in the cycle of capture, and by driving a writeback for that warp and register in exactly that cycle. It then fetches a reader of the register and judges the outcome at the issue port. The reader must stay stalled with its warp busy until a later writeback, and only then issue. A fetch that hits a slot in the cycle its warp is stalled is also checked at the ports, by the payload that finally issues.

// File: rtl/sched_pkg.sv
`timescale 1ns/1ps
package sched_pkg;
  typedef enum logic {
    PICK_ROUND_ROBIN = 1'b0,
    PICK_OLDEST      = 1'b1
  } pick_mode_e;
endpackage

// File: rtl/opnd_scoreboard.sv
`timescale 1ns/1ps
// Pending-result bits, one per register per warp; set on issue, cleared on writeback.
module opnd_scoreboard #(
  parameter int NUM_WARPS = 8,
  parameter int NUM_REGS  = 16,
  parameter int NUM_WB    = 2,
  localparam int WID_W = $clog2(NUM_WARPS),
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 set_en,
  input  logic [WID_W-1:0]                     set_warp,
  input  logic [REG_W-1:0]                     set_reg,
  input  logic [NUM_WB-1:0]                    wb_valid,
  input  logic [NUM_WB*WID_W-1:0]              wb_warp,
  input  logic [NUM_WB*REG_W-1:0]              wb_reg,
  output logic [NUM_WARPS-1:0][NUM_REGS-1:0]   pending
);
  logic [NUM_WARPS-1:0][NUM_REGS-1:0] clr_mask, set_mask, pend_nxt;
  logic upd_en;

  always_comb begin
    clr_mask = '0;
    set_mask = '0;
    for (int p = 0; p < NUM_WB; p++) begin
      if (wb_valid[p]) clr_mask[wb_warp[p*WID_W +: WID_W]][wb_reg[p*REG_W +: REG_W]] = 1'b1;
    end
    if (set_en) set_mask[set_warp][set_reg] = 1'b1;
    // a set in the same cycle as a clear of the same bit leaves it pending
    pend_nxt = (pending & ~clr_mask) | set_mask;
    upd_en   = set_en | (|wb_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pending <= '0;
    else if (upd_en) pending <= pend_nxt;
  end
endmodule

// File: rtl/issue_picker.sv
`timescale 1ns/1ps
// Chooses one requesting warp: rotating priority or oldest-fetch-first.
module issue_picker import sched_pkg::*; #(
  parameter int         NUM_WARPS = 8,
  parameter pick_mode_e MODE      = PICK_ROUND_ROBIN,
  localparam int WID_W = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] req,
  input  logic                 note_en,
  input  logic [WID_W-1:0]     note_warp,
  input  logic                 adv_en,
  output logic                 grant_vld,
  output logic [WID_W-1:0]     grant_idx
);
  if (MODE == PICK_ROUND_ROBIN) begin : g_rr
    logic [WID_W-1:0] rr_ptr, rr_ptr_nxt;
    logic unused_note;
    assign unused_note = ^{note_en, note_warp};

    always_comb begin
      grant_vld = 1'b0;
      grant_idx = '0;
      for (int off = NUM_WARPS - 1; off >= 0; off--) begin
        int cand;
        cand = int'(rr_ptr) + off;
        if (cand >= NUM_WARPS) cand = cand - NUM_WARPS;
        if (req[cand]) begin
          grant_vld = 1'b1;
          grant_idx = WID_W'(cand);
        end
      end
      rr_ptr_nxt = (int'(grant_idx) == NUM_WARPS - 1) ? '0 : grant_idx + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rr_ptr <= '0;
      else if (adv_en) rr_ptr <= rr_ptr_nxt;
    end
  end else begin : g_age
    // older[i][j] = 1: warp i was fetched before warp j
    logic [NUM_WARPS-1:0][NUM_WARPS-1:0] older, older_nxt;
    logic unused_adv;
    assign unused_adv = adv_en;

    always_comb begin
      grant_vld = 1'b0;
      grant_idx = '0;
      for (int i = 0; i < NUM_WARPS; i++) begin
        logic beaten;
        beaten = 1'b0;
        for (int j = 0; j < NUM_WARPS; j++) begin
          if (j != i && req[j] && older[j][i]) beaten = 1'b1;
        end
        if (req[i] && !beaten) begin
          grant_vld = 1'b1;
          grant_idx = WID_W'(i);
        end
      end
      older_nxt = older;
      for (int j = 0; j < NUM_WARPS; j++) begin
        older_nxt[note_warp][j] = 1'b0;
        older_nxt[j][note_warp] = (j != int'(note_warp));
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < NUM_WARPS; i++)
          for (int j = 0; j < NUM_WARPS; j++)
            older[i][j] <= (i < j);
      end else if (note_en) begin
        older <= older_nxt;
      end
    end
  end
endmodule

// File: rtl/issue_pacer.sv
`timescale 1ns/1ps
// Holds off the next issue until the pipe has finished broadcasting the last one.
module issue_pacer #(
  parameter int GAP = 4,
  localparam int CNT_W = (GAP > 1) ? $clog2(GAP) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic ok
);
  if (GAP > 1) begin : g_count
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic cnt_en;
    always_comb begin
      cnt_en  = fire | (cnt != '0);
      cnt_nxt = fire ? CNT_W'(GAP - 1) : cnt - 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (cnt_en) cnt <= cnt_nxt;
    end
    assign ok = (cnt == '0);
  end else begin : g_free
    logic unused_pace;
    assign unused_pace = ^{clk, rst_n, fire};
    assign ok = 1'b1;
  end
endmodule

// File: rtl/warp_issue_sched.sv
`timescale 1ns/1ps
module warp_issue_sched import sched_pkg::*; #(
  parameter int         NUM_WARPS = 8,
  parameter int         NUM_REGS  = 16,
  parameter int         OP_W      = 16,
  parameter int         NUM_WB    = 2,
  parameter int         ISSUE_GAP = 4,
  parameter pick_mode_e PICK_MODE = PICK_ROUND_ROBIN,
  localparam int WID_W = $clog2(NUM_WARPS),
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fetch_valid,
  input  logic [WID_W-1:0]        fetch_warp,
  input  logic [OP_W-1:0]         fetch_op,
  input  logic [REG_W-1:0]        fetch_dst,
  input  logic [REG_W-1:0]        fetch_src_a,
  input  logic [REG_W-1:0]        fetch_src_b,
  input  logic                    fetch_wr,
  input  logic [NUM_WB-1:0]       wb_valid,
  input  logic [NUM_WB*WID_W-1:0] wb_warp,
  input  logic [NUM_WB*REG_W-1:0] wb_reg,
  output logic                    issue_valid,
  output logic [WID_W-1:0]        issue_warp,
  output logic [OP_W-1:0]         issue_op,
  output logic [REG_W-1:0]        issue_dst,
  output logic                    issue_wr,
  output logic [NUM_WARPS-1:0]    warp_busy
);
  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  // instruction buffer: one slot per warp
  logic [NUM_WARPS-1:0] slot_vld, slot_vld_nxt, load_en, warp_rdy;
  logic [OP_W-1:0]      slot_op  [NUM_WARPS];
  logic [REG_W-1:0]     slot_dst [NUM_WARPS];
  logic [REG_W-1:0]     slot_sa  [NUM_WARPS];
  logic [REG_W-1:0]     slot_sb  [NUM_WARPS];
  logic                 slot_wr  [NUM_WARPS];

  logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend;
  logic             accept, grant_vld, pace_ok, issue_fire, vld_en;
  logic [WID_W-1:0] grant_idx;

  assign accept     = fetch_valid & ~slot_vld[fetch_warp];
  assign issue_fire = grant_vld & pace_ok;

  always_comb begin
    for (int w = 0; w < NUM_WARPS; w++) begin
      load_en[w]      = accept && (fetch_warp == WID_W'(w));
      slot_vld_nxt[w] = slot_vld[w];
      if (issue_fire && grant_idx == WID_W'(w)) slot_vld_nxt[w] = 1'b0;
      if (load_en[w])                           slot_vld_nxt[w] = 1'b1;
    end
    vld_en = accept | issue_fire;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  slot_vld <= '0;
    else if (vld_en)  slot_vld <= slot_vld_nxt;
  end

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    always_ff @(posedge clk) begin
      if (load_en[w]) begin
        slot_op[w]  <= fetch_op;
        slot_dst[w] <= fetch_dst;
        slot_sa[w]  <= fetch_src_a;
        slot_sb[w]  <= fetch_src_b;
        slot_wr[w]  <= fetch_wr;
      end
    end
    assign warp_rdy[w] = slot_vld[w]
                       & ~pend[w][slot_sa[w]]
                       & ~pend[w][slot_sb[w]]
                       & ~(slot_wr[w] & pend[w][slot_dst[w]]);
  end

  opnd_scoreboard #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .NUM_WB(NUM_WB)) u_scoreboard (
    .clk(clk), .rst_n(rst_core_n),
    .set_en(issue_fire & slot_wr[grant_idx]), .set_warp(grant_idx), .set_reg(slot_dst[grant_idx]),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
    .pending(pend)
  );

  issue_picker #(.NUM_WARPS(NUM_WARPS), .MODE(PICK_MODE)) u_picker (
    .clk(clk), .rst_n(rst_core_n), .req(warp_rdy),
    .note_en(accept), .note_warp(fetch_warp), .adv_en(issue_fire),
    .grant_vld(grant_vld), .grant_idx(grant_idx)
  );

  issue_pacer #(.GAP(ISSUE_GAP)) u_pacer (
    .clk(clk), .rst_n(rst_core_n), .fire(issue_fire), .ok(pace_ok)
  );

  assign issue_valid = issue_fire;
  assign issue_warp  = grant_idx;
  assign issue_op    = slot_op[grant_idx];
  assign issue_dst   = slot_dst[grant_idx];
  assign issue_wr    = slot_wr[grant_idx];
  assign warp_busy   = slot_vld;
endmodule

// File: rtl/sched_checks.sv
`timescale 1ns/1ps
module sched_checks #(
  parameter int NUM_WARPS = 8,
  parameter int ISSUE_GAP = 4,
  localparam int WID_W = $clog2(NUM_WARPS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fetch_valid,
  input logic [WID_W-1:0]     fetch_warp,
  input logic                 issue_valid,
  input logic [WID_W-1:0]     issue_warp,
  input logic [NUM_WARPS-1:0] warp_busy
);
  int  since_issue;
  bit  seen_issue;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_issue <= 0;
      seen_issue  <= 1'b0;
    end else if (issue_valid) begin
      since_issue <= 1;
      seen_issue  <= 1'b1;
    end else if (since_issue < ISSUE_GAP) begin
      since_issue <= since_issue + 1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_idle_in_reset_R1: assert (!issue_valid && warp_busy == '0)
        else $error("issue or busy seen while in reset");
    end
  end

  assert_issue_from_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> warp_busy[issue_warp]);

  assert_slot_freed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !warp_busy[$past(issue_warp)]);

  assert_issue_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && seen_issue) |-> (since_issue >= ISSUE_GAP));

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_busy
    assert_busy_needs_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(warp_busy[w]) |-> $past(fetch_valid && fetch_warp == WID_W'(w)));
  end
endmodule

bind warp_issue_sched sched_checks #(.NUM_WARPS(NUM_WARPS), .ISSUE_GAP(ISSUE_GAP)) u_sched_checks (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_warp(fetch_warp),
  .issue_valid(issue_valid), .issue_warp(issue_warp), .warp_busy(warp_busy)
);

// File: tb/test_warp_issue_sched.sv
`timescale 1ns/1ps
module test_warp_issue_sched;
  import sched_pkg::*;
  localparam int NW = 8, NR = 16, OPW = 16, NWB = 2, GAP = 4;
  localparam int WW = 3, RW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 1'b0;
  logic [WW-1:0] fetch_warp = '0;
  logic [OPW-1:0] fetch_op = '0;
  logic [RW-1:0] fetch_dst = '0, fetch_src_a = '0, fetch_src_b = '0;
  logic fetch_wr = 1'b0;
  logic [NWB-1:0] wb_valid = '0;
  logic [NWB*WW-1:0] wb_warp = '0;
  logic [NWB*RW-1:0] wb_reg = '0;

  logic iv0, iv1, iwr0, iwr1;
  logic [WW-1:0] iw0, iw1;
  logic [OPW-1:0] iop0, iop1;
  logic [RW-1:0] idst0, idst1;
  logic [NW-1:0] busy0, busy1;

  always #4 clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW), .NUM_REGS(NR), .OP_W(OPW), .NUM_WB(NWB),
    .ISSUE_GAP(GAP), .PICK_MODE(PICK_ROUND_ROBIN)) i_warp_issue_sched (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_warp(fetch_warp), .fetch_op(fetch_op),
    .fetch_dst(fetch_dst), .fetch_src_a(fetch_src_a), .fetch_src_b(fetch_src_b), .fetch_wr(fetch_wr),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
    .issue_valid(iv0), .issue_warp(iw0), .issue_op(iop0), .issue_dst(idst0), .issue_wr(iwr0),
    .warp_busy(busy0));

  warp_issue_sched #(.NUM_WARPS(NW), .NUM_REGS(NR), .OP_W(OPW), .NUM_WB(NWB),
    .ISSUE_GAP(GAP), .PICK_MODE(PICK_OLDEST)) i_warp_issue_sched_age (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_warp(fetch_warp), .fetch_op(fetch_op),
    .fetch_dst(fetch_dst), .fetch_src_a(fetch_src_a), .fetch_src_b(fetch_src_b), .fetch_wr(fetch_wr),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
    .issue_valid(iv1), .issue_warp(iw1), .issue_op(iop1), .issue_dst(idst1), .issue_wr(iwr1),
    .warp_busy(busy1));

  int total = 0, bad = 0, cyc = 0;
  bit finished = 1'b0;
  int log_n [2];
  int log_w [2][512];
  int log_c [2][512];
  int log_op[2][512];

  initial begin log_n[0] = 0; log_n[1] = 0; end
  always @(posedge clk) cyc = cyc + 1;

  always @(negedge clk) begin
    if (iv0 && log_n[0] < 512) begin
      log_w[0][log_n[0]] = int'(iw0); log_c[0][log_n[0]] = cyc; log_op[0][log_n[0]] = int'(iop0);
      log_n[0] = log_n[0] + 1;
    end
    if (iv1 && log_n[1] < 512) begin
      log_w[1][log_n[1]] = int'(iw1); log_c[1][log_n[1]] = cyc; log_op[1][log_n[1]] = int'(iop1);
      log_n[1] = log_n[1] + 1;
    end
  end

  task automatic check_eq(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; fetch_valid = 1'b0; wb_valid = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic fetch(int w, int op, int dst, int sa, int sb, bit wr, output int cap);
    fetch_valid = 1'b1; fetch_warp = WW'(w); fetch_op = OPW'(op);
    fetch_dst = RW'(dst); fetch_src_a = RW'(sa); fetch_src_b = RW'(sb); fetch_wr = wr;
    @(posedge clk); #1;
    fetch_valid = 1'b0;
    cap = cyc;
  endtask

  task automatic wb_one(int w, int r);
    wb_valid = 2'b01; wb_warp = '0; wb_reg = '0;
    wb_warp[0 +: WW] = WW'(w); wb_reg[0 +: RW] = RW'(r);
    @(posedge clk); #1;
    wb_valid = '0;
  endtask

  task automatic wb_two(int w0, int r0, int w1, int r1);
    wb_valid = 2'b11;
    wb_warp[0 +: WW] = WW'(w0); wb_reg[0 +: RW] = RW'(r0);
    wb_warp[WW +: WW] = WW'(w1); wb_reg[RW +: RW] = RW'(r1);
    @(posedge clk); #1;
    wb_valid = '0;
  endtask

  // R1: quiet after reset, all registers ready
  task automatic t_reset();
    int cap, base;
    do_reset();
    check_eq("R1", "issue_valid after reset", int'(iv0), 0);
    check_eq("R1", "warp_busy after reset", int'(busy0), 0);
    base = log_n[0];
    fetch(0, 'h0F0F, 15, 15, 15, 1'b1, cap);
    idle(1);
    check_eq("R1", "first instruction issues at once", log_n[0] - base, 1);
    check_eq("R1", "first issue cycle", log_c[0][base], cap);
  endtask

  // R2 R3 R4 R5 R6 R9: basic issue, RAW stall, other warp proceeds, release
  task automatic t_basic();
    int cap, base;
    do_reset();
    base = log_n[0];
    fetch(2, 'h1234, 5, 1, 2, 1'b1, cap);
    check_eq("R2", "busy after fetch", int'(busy0[2]), 1);
    idle(1);
    check_eq("R4", "issued warp", log_w[0][base], 2);
    check_eq("R4", "issued payload", log_op[0][base], 'h1234);
    check_eq("R4", "slot empty after issue", int'(busy0[2]), 0);
    fetch(2, 'h0002, 6, 5, 0, 1'b1, cap);
    fetch(4, 'h0004, 5, 5, 5, 1'b1, cap);
    idle(10);
    check_eq("R9", "only the other warp issued", log_n[0] - base, 2);
    check_eq("R9", "other warp id", log_w[0][base+1], 4);
    check_eq("R3", "reader still buffered", int'(busy0[2]), 1);
    wb_one(2, 5);
    idle(6);
    check_eq("R6", "reader released by writeback", log_n[0] - base, 3);
    check_eq("R6", "released payload", log_op[0][base+2], 'h0002);
  endtask

  // R3: destination pending blocks a second writer
  task automatic t_waw();
    int cap, base;
    do_reset();
    base = log_n[0];
    fetch(3, 'h0031, 7, 0, 0, 1'b1, cap);
    idle(2);
    fetch(3, 'h0032, 7, 1, 1, 1'b1, cap);
    idle(8);
    check_eq("R3", "second writer stalled", log_n[0] - base, 1);
    wb_one(3, 7);
    idle(6);
    check_eq("R3", "second writer issued after writeback", log_n[0] - base, 2);
    check_eq("R3", "second writer payload", log_op[0][base+1], 'h0032);
  endtask

  // R5: write flag clear marks nothing
  task automatic t_nowrite();
    int cap, base;
    do_reset();
    base = log_n[0];
    fetch(6, 'h0061, 4, 0, 0, 1'b0, cap);
    idle(2);
    fetch(6, 'h0062, 8, 4, 4, 1'b1, cap);
    idle(8);
    check_eq("R5", "reader of unwritten dst issues", log_n[0] - base, 2);
  endtask

  // R2: fetch into busy slot is ignored
  task automatic t_drop();
    int cap, base;
    do_reset();
    base = log_n[0];
    fetch(1, 'h0011, 3, 0, 0, 1'b1, cap);
    idle(2);
    fetch(1, 'h00AA, 9, 3, 0, 1'b1, cap);
    fetch(1, 'h00BB, 9, 0, 0, 1'b1, cap);
    idle(8);
    check_eq("R2", "no issue while stalled", log_n[0] - base, 1);
    wb_one(1, 3);
    idle(12);
    check_eq("R2", "exactly one later issue", log_n[0] - base, 2);
    check_eq("R2", "kept payload issued", log_op[0][base+1], 'h00AA);
    check_eq("R2", "slot empty at end", int'(busy0[1]), 0);
  endtask

  // R8: spacing exactly GAP while work waits
  task automatic t_pace();
    int c0, c1, c2, base;
    do_reset();
    base = log_n[0];
    fetch(0, 'h0100, 1, 0, 0, 1'b1, c0);
    fetch(1, 'h0101, 1, 0, 0, 1'b1, c1);
    fetch(2, 'h0102, 1, 0, 0, 1'b1, c2);
    idle(12);
    check_eq("R8", "three issues", log_n[0] - base, 3);
    check_eq("R8", "first issue cycle", log_c[0][base], c0);
    check_eq("R8", "second spacing", log_c[0][base+1] - log_c[0][base], GAP);
    check_eq("R8", "third spacing", log_c[0][base+2] - log_c[0][base+1], GAP);
  endtask

  // R10 R11: round-robin versus oldest first
  task automatic t_order();
    int cap, b0, b1;
    do_reset();
    b0 = log_n[0]; b1 = log_n[1];
    fetch(5, 'h0500, 1, 0, 0, 1'b1, cap);
    fetch(2, 'h0200, 1, 0, 0, 1'b1, cap);
    fetch(7, 'h0700, 1, 0, 0, 1'b1, cap);
    idle(12);
    check_eq("R10", "rr first", log_w[0][b0], 5);
    check_eq("R10", "rr second wraps past 5", log_w[0][b0+1], 7);
    check_eq("R10", "rr third", log_w[0][b0+2], 2);
    check_eq("R11", "age first", log_w[1][b1], 5);
    check_eq("R11", "age second oldest", log_w[1][b1+1], 2);
    check_eq("R11", "age third", log_w[1][b1+2], 7);
  endtask

  // R7: writeback and issue of same register collide
  task automatic t_collide();
    int cap, base;
    do_reset();
    base = log_n[0];
    fetch(1, 'h0190, 9, 0, 0, 1'b1, cap);
    wb_one(1, 9);
    check_eq("R7", "writer issued in collision cycle", log_c[0][base], cap);
    fetch(1, 'h0191, 2, 9, 0, 1'b0, cap);
    idle(8);
    check_eq("R7", "reader still stalled", log_n[0] - base, 1);
    check_eq("R7", "reader warp busy", int'(busy0[1]), 1);
    wb_one(1, 9);
    idle(6);
    check_eq("R7", "reader issued after later writeback", log_n[0] - base, 2);
  endtask

  // R6: per-warp isolation and two ports at once
  task automatic t_multi_wb();
    int cap, base;
    do_reset();
    fetch(0, 'h0003, 3, 0, 0, 1'b1, cap);
    fetch(5, 'h0053, 3, 0, 0, 1'b1, cap);
    fetch(7, 'h0072, 2, 0, 0, 1'b1, cap);
    idle(12);
    base = log_n[0];
    fetch(0, 'h00A0, 1, 3, 3, 1'b0, cap);
    fetch(5, 'h00A5, 1, 3, 3, 1'b0, cap);
    fetch(7, 'h00A7, 1, 2, 2, 1'b0, cap);
    idle(6);
    check_eq("R6", "all readers stalled", log_n[0] - base, 0);
    wb_one(0, 3);
    idle(8);
    check_eq("R6", "only warp 0 released", log_n[0] - base, 1);
    check_eq("R6", "released warp id", log_w[0][base], 0);
    check_eq("R6", "warp 5 same reg still pending", int'(busy0[5]), 1);
    wb_two(5, 3, 7, 2);
    idle(12);
    check_eq("R6", "both ports released", log_n[0] - base, 3);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_waw();
    t_nowrite();
    t_drop();
    t_pace();
    t_order();
    t_collide();
    t_multi_wb();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule